// File: doc/BRIEF.md
# Four-Source Priority Handshake Collector

This block gathers address words from four downstream sources that share a single 14-bit address bus. Each source announces a pending word by pulling its own active-low valid line. A purely combinational priority stage watches the raw valid lines. It grants the bus to the lowest-numbered requesting source by pulling that source's active-low select line. It also produces a 2-bit tag holding that source's index.

A three-state sequencer paces each transfer. It starts only when a synchronized copy of the valid lines shows a request and the downstream buffer reports free space. It then raises a one-cycle pair of strobes: an active-low done to the sources and an active-high latch strobe to the buffer. The tagged word is captured on the edge that ends that pair. A further settle cycle lets the granted source react to done before a new decision is made.

An operating-code input gates the whole sequencer. Any code other than the collect code holds the sequencer in halt and clears the captured word.

Top module: `prio_collector`

## Requirements
- R1: selN is active low; whenever at least one validN bit is low, exactly one selN bit is low. With every validN bit high, selN is all ones and tag is 0.
- R2: Among low validN bits, the lowest index wins: validN[0] has the highest priority and validN[3] the lowest. Selection follows the raw lines in the same cycle.
- R3: tag equals the binary index of the granted source. capAddr[15:14] holds that tag and capAddr[13:0] the bus word, both taken on the capture edge.
- R4: Let a valid bit go low before rising edge E1, with the sequencer halted, bufFull low and opCode equal to the collect code (4'hC). Then latchStrobe is high in the cycle after E2, and capAddr takes the word on E3.
- R5: doneN is low exactly while latchStrobe is high, for one cycle per transfer. At least two strobe-free cycles follow, so back-to-back transfers repeat every three cycles.
- R6: bufFull is examined only in halt. While it is high at a halt decision, no strobe starts. A transfer already started runs to its end.
- R7: While opCode differs from 4'hC, no strobe is produced in the following cycle, the sequencer returns to halt, and capAddr reads 0.
- R8: A source that advances its word on each done it sees while selected has every word captured exactly once, in its own queue order, with its own tag.
- R9: During reset, doneN is high, latchStrobe low and capAddr 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opCode | input | 4 | Operating code; 4'hC enables collection |
| validN | input | 4 | Active-low data-valid per source |
| busAddr | input | 14 | Shared address bus driven by the selected source |
| bufFull | input | 1 | Downstream buffer has no room |
| selN | output | 4 | Active-low grant per source, combinational |
| doneN | output | 1 | Active-low word-accepted strobe to the sources |
| latchStrobe | output | 1 | Capture strobe to the buffer |
| tag | output | 2 | Index of the granted source |
| capAddr | output | 16 | Tagged captured word {tag, busAddr} |

## Verification
The awkward coincidence is a capture cycle in which a higher-priority source raises its valid line. The grant then moves under a strobe that has already started. The capture, the tag and the done must all follow the new source, and the old source must keep its word. The bench forces this by adding words to source 0 just after a transfer from source 2 has started. It then checks that source 0's word is taken and that source 2's words still arrive later in order. A second coincidence sets bufFull in the very cycle the synchronized start first shows a request. The per-cycle model expects the sequencer to stay halted until the flag clears.

// File: rtl/pc_pkg.sv
package pc_pkg;

  // One-hot sequencer states: halt, grab (strobes active), settle
  typedef enum logic [2:0] {
    ST_HALT = 3'b001,
    ST_GRAB = 3'b010,
    ST_WAIT = 3'b100
  } pcState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic latch;   // capture {tag, bus} on the next edge
    logic clear;   // wipe the capture register
  } pcStrobe_t;

endpackage

// File: rtl/pc_datapath.sv
module pc_datapath
  import pc_pkg::*;
#(
  parameter int SRC_COUNT = 4,
  parameter int ADDR_W    = 14,
  parameter int TAG_W     = 2,
  localparam int CAP_W    = TAG_W + ADDR_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SRC_COUNT-1:0] validN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  pcStrobe_t            strobes,
  output logic [SRC_COUNT-1:0] selN,
  output logic [TAG_W-1:0]     tag,
  output logic                 startReq,
  output logic [CAP_W-1:0]     capAddr
);

  logic [SRC_COUNT-1:0] validSync;

  // One synchronizing flop per source line (active-high internally)
  for (genvar g = 0; g < SRC_COUNT; g++) begin : gSync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) validSync[g] <= 1'b0;
      else        validSync[g] <= ~validN[g];
    end
  end

  assign startReq = |validSync;

  // Combinational priority grant on the raw lines, index 0 first
  always_comb begin
    logic found;
    found = 1'b0;
    selN  = '1;
    tag   = '0;
    for (int i = 0; i < SRC_COUNT; i++) begin
      if (!found && !validN[i]) begin
        found   = 1'b1;
        selN[i] = 1'b0;
        tag     = TAG_W'(i);
      end
    end
  end

  // Capture register: clear has precedence over a pending capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             capAddr <= '0;
    else if (strobes.clear) capAddr <= '0;
    else if (strobes.latch) capAddr <= {tag, busAddr};
  end

endmodule

// File: rtl/pc_control.sv
module pc_control
  import pc_pkg::*;
#(
  parameter int              OP_W      = 4,
  parameter logic [OP_W-1:0] OP_OUTPUT = 4'hC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] opCode,
  input  logic            startReq,
  input  logic            bufFull,
  output pcStrobe_t       strobes,
  output logic            doneOut
);

  pcState_t curState, nextState;
  logic     opMatch;
  logic     doneQ, latchQ;

  assign opMatch = (opCode == OP_OUTPUT);

  always_comb begin
    nextState = curState;
    if (!opMatch) begin
      nextState = ST_HALT;
    end else begin
      case (curState)
        ST_HALT: if (startReq && !bufFull) nextState = ST_GRAB;
        ST_GRAB: nextState = ST_WAIT;
        ST_WAIT: nextState = ST_HALT;
        default: nextState = ST_HALT;
      endcase
    end
  end

  // State plus two parallel output flops, all loaded from the next state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curState <= ST_HALT;
      doneQ    <= 1'b0;
      latchQ   <= 1'b0;
    end else begin
      curState <= nextState;
      doneQ    <= (nextState == ST_GRAB);
      latchQ   <= (nextState == ST_GRAB);
    end
  end

  always_comb begin
    strobes.latch = latchQ;
    strobes.clear = !opMatch;
  end

  assign doneOut = doneQ;

endmodule

// File: rtl/prio_collector.sv
module prio_collector
  import pc_pkg::*;
#(
  parameter int              SRC_COUNT = 4,
  parameter int              ADDR_W    = 14,
  parameter int              OP_W      = 4,
  parameter logic [OP_W-1:0] OP_OUTPUT = 4'hC,
  localparam int             TAG_W     = (SRC_COUNT > 1) ? $clog2(SRC_COUNT) : 1,
  localparam int             CAP_W     = TAG_W + ADDR_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [OP_W-1:0]      opCode,
  input  logic [SRC_COUNT-1:0] validN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 bufFull,
  output logic [SRC_COUNT-1:0] selN,
  output logic                 doneN,
  output logic                 latchStrobe,
  output logic [TAG_W-1:0]     tag,
  output logic [CAP_W-1:0]     capAddr
);

  pcStrobe_t strobes;
  logic      startReq;
  logic      doneOut;

  pc_control #(
    .OP_W      (OP_W),
    .OP_OUTPUT (OP_OUTPUT)
  ) u_control (
    .clk      (clk),
    .rst_n    (rst_n),
    .opCode   (opCode),
    .startReq (startReq),
    .bufFull  (bufFull),
    .strobes  (strobes),
    .doneOut  (doneOut)
  );

  pc_datapath #(
    .SRC_COUNT (SRC_COUNT),
    .ADDR_W    (ADDR_W),
    .TAG_W     (TAG_W)
  ) u_datapath (
    .clk      (clk),
    .rst_n    (rst_n),
    .validN   (validN),
    .busAddr  (busAddr),
    .strobes  (strobes),
    .selN     (selN),
    .tag      (tag),
    .startReq (startReq),
    .capAddr  (capAddr)
  );

  assign doneN       = ~doneOut;
  assign latchStrobe = strobes.latch;

endmodule

// File: rtl/prio_collector_chk.sv
module prio_collector_chk #(
  parameter int              SRC_COUNT = 4,
  parameter int              OP_W      = 4,
  parameter logic [OP_W-1:0] OP_OUTPUT = 4'hC,
  parameter int              TAG_W     = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [OP_W-1:0]      opCode,
  input logic [SRC_COUNT-1:0] validN,
  input logic                 bufFull,
  input logic [SRC_COUNT-1:0] selN,
  input logic                 doneN,
  input logic                 latchStrobe,
  input logic [TAG_W-1:0]     tag
);

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (~validN != '0) |-> ($countones(~selN) == 1)); // R1

  AST_SEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (&validN) |-> ((&selN) && (tag == '0))); // R1

  AST_PRIO_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    !validN[0] |-> !selN[0]); // R2

  AST_TAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (~validN != '0) |-> !selN[tag]); // R3

  AST_DONE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    latchStrobe == !doneN); // R5

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    latchStrobe |=> !latchStrobe); // R5

  AST_PULSE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(latchStrobe) |=> !latchStrobe); // R5

  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latchStrobe) |-> $past(!bufFull)); // R6

  AST_OP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (opCode != OP_OUTPUT) |=> !latchStrobe); // R7

endmodule

bind prio_collector prio_collector_chk #(
  .SRC_COUNT (SRC_COUNT),
  .OP_W      (OP_W),
  .OP_OUTPUT (OP_OUTPUT),
  .TAG_W     (TAG_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .opCode      (opCode),
  .validN      (validN),
  .bufFull     (bufFull),
  .selN        (selN),
  .doneN       (doneN),
  .latchStrobe (latchStrobe),
  .tag         (tag)
);

// File: tb/tb_prio_collector.sv
module tb_prio_collector;

  localparam logic [3:0] OPC_COLLECT = 4'hC;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  opCode;
  logic [3:0]  validN;
  logic [13:0] busAddr;
  logic        bufFull;
  logic [3:0]  selN;
  logic        doneN;
  logic        latchStrobe;
  logic [1:0]  tag;
  logic [15:0] capAddr;

  always #5 clk = ~clk;

  prio_collector dut (
    .clk(clk), .rst_n(rst_n), .opCode(opCode), .validN(validN),
    .busAddr(busAddr), .bufFull(bufFull), .selN(selN), .doneN(doneN),
    .latchStrobe(latchStrobe), .tag(tag), .capAddr(capAddr)
  );

  // Source models: one word queue per source
  logic [13:0] srcMem [4][16];
  int          head [4];
  int          tail [4];
  logic [13:0] nextWord;

  always_comb begin
    for (int i = 0; i < 4; i++) validN[i] = (head[i] == tail[i]);
  end

  always_comb begin
    busAddr = '0;
    for (int i = 0; i < 4; i++)
      if (!selN[i] && head[i] != tail[i]) busAddr = srcMem[i][head[i]];
  end

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(input int s, input int n);
    for (int k = 0; k < n; k++) begin
      srcMem[s][tail[s]] = nextWord;
      nextWord = nextWord + 14'h0A3;
      tail[s]++;
    end
  endtask

  function automatic int pickSrc(input logic [3:0] vN);
    for (int i = 0; i < 4; i++) if (!vN[i]) return i;
    return -1;
  endfunction

  // Reference model state
  int          mState;   // 0 halt, 1 strobes active, 2 settle
  bit          mSync;
  logic [15:0] mCap;

  // Snapshots taken mid-cycle
  logic [3:0]  snapValid;
  logic        snapFull, snapRst, snapDone;
  logic [3:0]  snapOp, snapSel;
  logic [15:0] snapExpWord;

  logic [15:0] capLog [64];
  int          capCnt;
  bit          prevLatch;

  task automatic stimulus(input int cyc);
    case (cyc)
      3:   rst_n = 1'b1;
      5:   opCode = OPC_COLLECT;
      8:   push(2, 3);
      10:  push(0, 2);                      // arrives in the strobe cycle
      12:  begin push(3, 2); push(1, 2); end
      45:  bufFull = 1'b1;
      46:  push(1, 3);
      60:  bufFull = 1'b0;
      75:  push(0, 1);
      76:  bufFull = 1'b1;                  // full rises as start is first seen
      80:  bufFull = 1'b0;
      100: opCode = 4'h3;
      102: push(3, 2);
      115: opCode = OPC_COLLECT;
      150: begin push(0, 2); push(1, 2); push(2, 2); push(3, 2); end
      default: ;
    endcase
  endtask

  initial begin
    rst_n = 1'b0; opCode = 4'h0; bufFull = 1'b0;
    nextWord = 14'h0101;
    for (int i = 0; i < 4; i++) begin head[i] = 0; tail[i] = 0; end
    mState = 0; mSync = 0; mCap = '0; capCnt = 0; prevLatch = 0;

    for (int cyc = 0; cyc < 260; cyc++) begin
      @(negedge clk);
      begin
        int es;
        logic [3:0] expSel;
        logic [1:0] expTag;
        string rSel, rLat, rDone, rCap;
        es = pickSrc(validN);
        expSel = '1; expTag = '0;
        if (es >= 0) begin expSel[es] = 1'b0; expTag = es[1:0]; end
        rSel  = ($countones(~validN) > 1) ? "R2" : "R1";
        rLat  = !rst_n ? "R9" : (opCode != OPC_COLLECT) ? "R7" : bufFull ? "R6" : "R4";
        rDone = !rst_n ? "R9" : "R5";
        rCap  = !rst_n ? "R9" : (opCode != OPC_COLLECT) ? "R7" : "R3";
        chk(selN == expSel, rSel, "selN", 32'(selN), 32'(expSel));
        chk(tag == expTag, "R3", "tag", 32'(tag), 32'(expTag));
        chk(latchStrobe == (mState == 1), rLat, "latchStrobe",
            32'(latchStrobe), 32'(mState == 1));
        chk(doneN == !(mState == 1), rDone, "doneN", 32'(doneN), 32'(!(mState == 1)));
        chk(capAddr == mCap, rCap, "capAddr", 32'(capAddr), 32'(mCap));

        if (prevLatch && capCnt < 64) begin capLog[capCnt] = capAddr; capCnt++; end
        prevLatch = latchStrobe;

        snapValid = validN; snapFull = bufFull; snapRst = rst_n; snapOp = opCode;
        snapDone = !doneN; snapSel = selN;
        snapExpWord = (es >= 0) ? {expTag, srcMem[es][head[es]]} : 16'h0;
      end

      @(posedge clk);
      if (!snapRst) begin
        mState = 0; mSync = 0; mCap = '0;
      end else begin
        bit opOk;
        int nxt;
        opOk = (snapOp == OPC_COLLECT);
        if (!opOk)            nxt = 0;
        else if (mState == 0) nxt = (mSync && !snapFull) ? 1 : 0;
        else if (mState == 1) nxt = 2;
        else                  nxt = 0;
        if (!opOk)             mCap = '0;
        else if (mState == 1)  mCap = snapExpWord;
        mSync  = (snapValid != 4'hF);
        mState = nxt;
      end

      #1;
      if (snapDone)
        for (int i = 0; i < 4; i++)
          if (!snapSel[i] && head[i] < tail[i]) head[i]++;
      stimulus(cyc);
    end

    // Exactly-once and per-source order
    for (int i = 0; i < 4; i++) begin
      int k;
      k = 0;
      chk(head[i] == tail[i], "R8", "source drained", 32'(head[i]), 32'(tail[i]));
      for (int j = 0; j < capCnt; j++) begin
        if (capLog[j][15:14] == i[1:0]) begin
          chk(k < tail[i] && capLog[j][13:0] == srcMem[i][k & 15], "R8", "capture order",
              32'(capLog[j]), 32'({i[1:0], srcMem[i][k & 15]}));
          k++;
        end
      end
      chk(k == tail[i], "R8", "capture count", 32'(k), 32'(tail[i]));
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule